// File: doc/BRIEF.md
# Packed dual-lane half-precision ALU

This unit performs one floating-point operation on two binary16 values that share a 32-bit word. Each cycle it may accept three packed source words and a 5-bit operation code. Both 16-bit halves of every word go through the same operation, and the two halves never exchange data. The unit returns one packed 32-bit result, with a valid flag, exactly one clock later. The operations are fused multiply-add, add, multiply, minimum and maximum. Add and multiply reuse the fused datapath, so every arithmetic result is rounded once.

Arithmetic follows binary16 with round-to-nearest, ties-to-even. Subnormal operands and results are kept, not flushed. An arithmetic NaN always comes out as one canonical quiet NaN. Minimum and maximum treat NaN as a missing value, and they order negative zero below positive zero.

Top module: `hp_packed_alu`

## Requirements
- R1: The operation code selects the operation for both lanes: 14 is fused multiply-add (a*b+c), 15 is add (a+b), 16 is multiply (a*b), 17 is minimum of a and b, and 18 is maximum of a and b.
- R2: In every source word, lane 0 is bits 15:0 and lane 1 is bits 31:16. The result uses the same layout. A lane's result depends only on that lane's inputs.
- R3: Fused multiply-add forms the exact value of a*b+c and rounds it once to binary16, to nearest with ties to even. Subnormal inputs and outputs are fully supported.
- R4: Add and multiply ignore source c completely: any value of c gives the same result.
- R5: A finite result whose magnitude rounds beyond the largest finite value becomes infinity (0x7C00) with the result's sign. Rounding never produces a NaN from finite operands.
- R6: Every NaN produced by add, multiply or fused multiply-add is 0x7E00. This covers any NaN operand, infinity times zero, and the sum of opposite infinities.
- R7: In minimum or maximum, if exactly one operand is a NaN (exponent field all ones, fraction nonzero), the other operand is returned. If both are NaN, the result is 0x7E00.
- R8: Minimum treats -0 (0x8000) as smaller than +0 (0x0000), and maximum treats +0 as larger than -0.
- R9: Any operation code other than 14 to 18 gives an all-zero result word.
- R10: The output valid flag equals the input valid flag one clock earlier. The result register loads only when the input valid flag is high and holds its value otherwise.
- R11: A synchronous active-high reset clears the output valid flag and the result word to zero.
- R12: An exact zero sum is +0, except when both the product and the addend are zeros of negative sign, which gives -0. A product of zeros takes the XOR of the operand signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation code are present this cycle |
| in_op | input | 5 | Operation code |
| in_src_a | input | 32 | Packed source a |
| in_src_b | input | 32 | Packed source b |
| in_src_c | input | 32 | Packed source c (addend of the fused operation) |
| out_valid | output | 1 | Result word is new this cycle |
| out_result | output | 32 | Packed result |

## Verification
The bench builds the unit with its default of two lanes over the fixed binary16 format. This lets one packed word carry an ordinary value in one lane and a special value (NaN, infinity, signed zero or subnormal) in the other, so lane isolation is tested on every vector. Directed words cover:
- a product whose early rounding would change the fused result,
- ties that round to zero in the subnormal range,
- overflow at the top of the finite range,
- NaN ordering in minimum and maximum.

A long stream of biased random operands and operation codes, including undefined codes and idle cycles, is then checked against an exact wide-integer model.

// File: rtl/hp_alu_pkg.sv
package hp_alu_pkg;

    localparam int HALF_W = 16;
    localparam int EXP_W  = 5;
    localparam int MAN_W  = 10;
    localparam int SIG_W  = MAN_W + 1;
    localparam int OP_W   = 5;
    // Bit position of one unit of the smallest subnormal in a sig<<(exp-1) scale
    localparam int FRAC   = (1 << (EXP_W - 1)) - 2 + MAN_W;
    // Exact product+addend in units of 2^-(2*FRAC): product significand plus
    // the largest finite exponent shift of both factors, plus a carry bit
    localparam int ACC_W  = 2 * SIG_W + 2 * ((1 << EXP_W) - 3) + 2;
    localparam int SH_W   = $clog2(ACC_W) + 1;
    localparam int KEEP_W = SIG_W + 1;
    localparam int ENC_W  = HALF_W + 2;

    typedef enum logic [OP_W-1:0] {
        OP_FMA = 5'd14,
        OP_ADD = 5'd15,
        OP_MUL = 5'd16,
        OP_MIN = 5'd17,
        OP_MAX = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } half_t;

    localparam logic [HALF_W-2:0] INF_MAG  = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam half_t             QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam half_t             ONE      = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};
    localparam half_t             NEG_ZERO = {1'b1, {(HALF_W-1){1'b0}}};

    function automatic logic is_nan(half_t h);
        return (&h.exp) && (|h.man);
    endfunction

    function automatic logic is_inf(half_t h);
        return (&h.exp) && !(|h.man);
    endfunction

    function automatic logic is_zero(half_t h);
        return !(|h.exp) && !(|h.man);
    endfunction

    function automatic logic [SIG_W-1:0] sig_of(half_t h);
        return {|h.exp, h.man};
    endfunction

    function automatic logic [EXP_W-1:0] eff_exp(half_t h);
        return (|h.exp) ? h.exp : EXP_W'(1);
    endfunction

    // Unsigned key whose order matches numeric order, with -0 below +0
    function automatic logic [HALF_W-1:0] order_key(half_t h);
        return h.sign ? ~h : {1'b1, h.exp, h.man};
    endfunction

endpackage

// File: rtl/hp_round_pack.sv
module hp_round_pack
    import hp_alu_pkg::*;
(
    input  logic             sign,
    input  logic [ACC_W-1:0] mag,
    output half_t            y
);

    logic [SH_W-1:0]   lead;
    logic [SH_W-1:0]   qsh;
    logic [KEEP_W-1:0] kept;
    logic [KEEP_W-1:0] rnd;
    logic [ACC_W-1:0]  half_bit;
    logic              guard;
    logic              sticky;
    logic              up;
    logic [ENC_W-1:0]  enc;

    always_comb begin
        lead = '0;
        for (int i = 0; i < ACC_W; i++) begin
            if (mag[i]) lead = SH_W'(i);
        end
    end

    always_comb begin
        // Quantum: the unit of the last kept fraction bit, never below the subnormal unit
        qsh      = (lead > SH_W'(FRAC + MAN_W)) ? lead - SH_W'(MAN_W) : SH_W'(FRAC);
        kept     = KEEP_W'(mag >> qsh);
        half_bit = ACC_W'(1) << (qsh - SH_W'(1));
        guard    = |(mag & half_bit);
        sticky   = |(mag & (half_bit - ACC_W'(1)));
        up       = guard & (sticky | kept[0]);
        rnd      = kept + KEEP_W'(up);
        // Exponent field and significand add, so a rounding carry moves up a binade
        enc      = (ENC_W'(qsh - SH_W'(FRAC)) << MAN_W) + ENC_W'(rnd);
        if (enc >= ENC_W'(INF_MAG)) y = half_t'({sign, INF_MAG});
        else                        y = half_t'({sign, (HALF_W-1)'(enc)});
    end

    always_comb begin
        assert_round_no_nan_R5: assert (!(&y.exp) || y.man == '0);
    end

endmodule

// File: rtl/hp_fma_lane.sv
module hp_fma_lane
    import hp_alu_pkg::*;
(
    input  half_t a,
    input  half_t b,
    input  half_t c,
    output half_t y
);

    logic [SIG_W-1:0]   sa, sb, sc;
    logic [2*SIG_W-1:0] sprod;
    logic [ACC_W-1:0]   pm, cm, mag;
    logic               ps, rs;
    logic               any_nan, p_inf, p_zero;
    half_t              rounded;

    always_comb begin
        sa    = sig_of(a);
        sb    = sig_of(b);
        sc    = sig_of(c);
        sprod = sa * sb;
        pm    = ACC_W'(sprod) << (SH_W'(eff_exp(a)) + SH_W'(eff_exp(b)) - SH_W'(2));
        cm    = ACC_W'(sc) << (SH_W'(eff_exp(c)) + SH_W'(FRAC - 1));
        ps    = a.sign ^ b.sign;
        if (ps == c.sign) begin
            mag = pm + cm;
            rs  = ps;
        end else if (pm >= cm) begin
            mag = pm - cm;
            rs  = ps;
        end else begin
            mag = cm - pm;
            rs  = c.sign;
        end
    end

    hp_round_pack u_round (
        .sign (rs),
        .mag  (mag),
        .y    (rounded)
    );

    always_comb begin
        any_nan = is_nan(a) | is_nan(b) | is_nan(c);
        p_inf   = is_inf(a) | is_inf(b);
        p_zero  = is_zero(a) | is_zero(b);
        if (any_nan || (p_inf && p_zero))
            y = QNAN;
        else if (p_inf)
            y = (is_inf(c) && (c.sign != ps)) ? QNAN : half_t'({ps, INF_MAG});
        else if (is_inf(c))
            y = c;
        else if (mag == '0)
            y = half_t'({p_zero & is_zero(c) & ps & c.sign, {(HALF_W-1){1'b0}}});
        else
            y = rounded;
    end

    always_comb begin
        assert_canonical_nan_R6: assert (!((&y.exp) && (|y.man)) || y == QNAN);
    end

endmodule

// File: rtl/hp_minmax_lane.sv
module hp_minmax_lane
    import hp_alu_pkg::*;
(
    input  half_t a,
    input  half_t b,
    input  logic  pick_max,
    output half_t y
);

    logic a_below;

    always_comb begin
        a_below = order_key(a) < order_key(b);
        if (is_nan(a) && is_nan(b)) y = QNAN;
        else if (is_nan(a))         y = b;
        else if (is_nan(b))         y = a;
        else if (pick_max)          y = a_below ? b : a;
        else                        y = a_below ? a : b;
    end

    always_comb begin
        assert_pick_operand_R7: assert (y == a || y == b || y == QNAN);
        assert_zero_order_R8: assert (!(is_zero(a) && is_zero(b) && a.sign != b.sign)
                                      || y.sign == !pick_max);
    end

endmodule

// File: rtl/hp_packed_alu.sv
module hp_packed_alu
    import hp_alu_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [OP_W-1:0]         in_op,
    input  logic [LANES*HALF_W-1:0] in_src_a,
    input  logic [LANES*HALF_W-1:0] in_src_b,
    input  logic [LANES*HALF_W-1:0] in_src_c,
    output logic                    out_valid,
    output logic [LANES*HALF_W-1:0] out_result
);

    localparam int WORD_W = LANES * HALF_W;

    logic is_add, is_mul, is_arith, is_minmax, op_known;
    logic [LANES-1:0][HALF_W-1:0] lane_res;

    assign is_add    = (in_op == OP_ADD);
    assign is_mul    = (in_op == OP_MUL);
    assign is_arith  = (in_op == OP_FMA) | is_add | is_mul;
    assign is_minmax = (in_op == OP_MIN) | (in_op == OP_MAX);
    assign op_known  = is_arith | is_minmax;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        half_t a, b, c, fb, fc, fy, my;

        assign a  = half_t'(in_src_a[g*HALF_W +: HALF_W]);
        assign b  = half_t'(in_src_b[g*HALF_W +: HALF_W]);
        assign c  = half_t'(in_src_c[g*HALF_W +: HALF_W]);
        // add runs as a*1+b, multiply as a*b+(-0): both exact before the single rounding
        assign fb = is_add ? ONE : b;
        assign fc = is_add ? b : (is_mul ? NEG_ZERO : c);

        hp_fma_lane u_fma (
            .a (a),
            .b (fb),
            .c (fc),
            .y (fy)
        );

        hp_minmax_lane u_minmax (
            .a        (a),
            .b        (b),
            .pick_max (in_op == OP_MAX),
            .y        (my)
        );

        assign lane_res[g] = is_arith  ? fy :
                             is_minmax ? my : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= WORD_W'(lane_res);
        end
    end

    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
    assert_unknown_op_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_known) |=> out_result == '0);
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

endmodule

// File: tb/test_hp_packed_alu.sv
`timescale 1ns/1ps
module test_hp_packed_alu;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [4:0]   in_op = '0;
    logic [W-1:0] in_src_a = '0;
    logic [W-1:0] in_src_b = '0;
    logic [W-1:0] in_src_c = '0;
    logic         out_valid;
    logic [W-1:0] out_result;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic         exp_valid = 1'b0;
    logic [W-1:0] exp_result = '0;

    always #4 clk = ~clk;

    hp_packed_alu i_hp_packed_alu (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_src_a   (in_src_a),
        .in_src_b   (in_src_b),
        .in_src_c   (in_src_c),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // ---------------- behavioural reference ----------------
    function automatic bit f_nan(logic [15:0] h);
        return h[14:10] == 5'h1f && h[9:0] != 0;
    endfunction
    function automatic bit f_inf(logic [15:0] h);
        return h[14:0] == 15'h7c00;
    endfunction
    function automatic bit f_zero(logic [15:0] h);
        return h[14:0] == 15'h0;
    endfunction

    // value times 2^24 as an exact signed integer
    function automatic logic signed [127:0] sc24(logic [15:0] h);
        logic signed [127:0] m;
        if (h[14:10] == 0) m = 128'(h[9:0]);
        else               m = 128'({1'b1, h[9:0]}) << (h[14:10] - 1);
        return h[15] ? -m : m;
    endfunction

    // value of a non-negative code times 2^48; 0x7C00 stands for 2^16
    function automatic logic signed [127:0] code_val(int e);
        if (e == 'h7c00) return 128'sd1 <<< 64;
        return sc24(16'(e)) <<< 24;
    endfunction

    // nearest code to a positive magnitude given times 2^48, ties to even code
    function automatic logic [15:0] nearest(bit sgn, logic signed [127:0] m);
        int lo = 0;
        int hi = 'h7c00;
        int pick;
        logic signed [127:0] dl, dh;
        while (lo < hi) begin
            int mid = (lo + hi + 1) / 2;
            if (code_val(mid) <= m) lo = mid;
            else hi = mid - 1;
        end
        if (lo == 'h7c00) pick = lo;
        else begin
            dl = m - code_val(lo);
            dh = code_val(lo + 1) - m;
            if (dl < dh)      pick = lo;
            else if (dh < dl) pick = lo + 1;
            else              pick = (lo % 2 == 1) ? lo + 1 : lo;
        end
        return {sgn, 15'(pick)};
    endfunction

    function automatic logic [15:0] finish_exact(logic signed [127:0] t, bit zsign);
        if (t == 0) return {zsign, 15'h0};
        if (t < 0) return nearest(1'b1, -t);
        return nearest(1'b0, t);
    endfunction

    function automatic logic [15:0] add_ref(logic [15:0] a, logic [15:0] b);
        if (f_nan(a) || f_nan(b)) return 16'h7e00;
        if (f_inf(a) && f_inf(b)) return (a[15] != b[15]) ? 16'h7e00 : a;
        if (f_inf(a)) return a;
        if (f_inf(b)) return b;
        return finish_exact((sc24(a) + sc24(b)) <<< 24,
                            f_zero(a) && f_zero(b) && a[15] && b[15]);
    endfunction

    function automatic logic [15:0] mul_ref(logic [15:0] a, logic [15:0] b);
        bit s = a[15] ^ b[15];
        if (f_nan(a) || f_nan(b)) return 16'h7e00;
        if ((f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b))) return 16'h7e00;
        if (f_inf(a) || f_inf(b)) return {s, 15'h7c00};
        return finish_exact(sc24(a) * sc24(b), s);
    endfunction

    function automatic logic [15:0] fma_ref(logic [15:0] a, logic [15:0] b, logic [15:0] c);
        bit s = a[15] ^ b[15];
        bit pz = f_zero(a) || f_zero(b);
        bit pi = f_inf(a) || f_inf(b);
        if (f_nan(a) || f_nan(b) || f_nan(c)) return 16'h7e00;
        if (pi && pz) return 16'h7e00;
        if (pi) return (f_inf(c) && c[15] != s) ? 16'h7e00 : {s, 15'h7c00};
        if (f_inf(c)) return c;
        return finish_exact(sc24(a) * sc24(b) + (sc24(c) <<< 24),
                            pz && f_zero(c) && s && c[15]);
    endfunction

    function automatic logic [15:0] minmax_ref(logic [15:0] a, logic [15:0] b, bit want_max);
        bit a_less;
        if (f_nan(a) && f_nan(b)) return 16'h7e00;
        if (f_nan(a)) return b;
        if (f_nan(b)) return a;
        a_less = (sc24(a) < sc24(b)) || (sc24(a) == sc24(b) && a[15] && !b[15]);
        if (want_max) return a_less ? b : a;
        return a_less ? a : b;
    endfunction

    function automatic logic [W-1:0] word_ref(logic [4:0] op, logic [W-1:0] a,
                                              logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] r = '0;
        for (int l = 0; l < W / 16; l++) begin
            logic [15:0] la = a[l*16 +: 16];
            logic [15:0] lb = b[l*16 +: 16];
            logic [15:0] lc = c[l*16 +: 16];
            logic [15:0] lr;
            case (op)
                5'd14:   lr = fma_ref(la, lb, lc);
                5'd15:   lr = add_ref(la, lb);
                5'd16:   lr = mul_ref(la, lb);
                5'd17:   lr = minmax_ref(la, lb, 1'b0);
                5'd18:   lr = minmax_ref(la, lb, 1'b1);
                default: lr = 16'h0;
            endcase
            r[l*16 +: 16] = lr;
        end
        return r;
    endfunction

    // ---------------- checking ----------------
    task automatic compare(input string tag);
        checks++;
        if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL R10 (%s) out_valid got %0b expected %0b", tag, out_valid, exp_valid);
        end
        checks++;
        if (out_result !== exp_result) begin
            errors++;
            $display("FAIL %s out_result got %08h expected %08h", tag, out_result, exp_result);
        end
    endtask

    // called at a falling edge: drive, let one rising edge pass, check at the next falling edge
    task automatic step(input logic v, input logic [4:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] c, input string tag);
        in_valid = v;
        in_op    = op;
        in_src_a = a;
        in_src_b = b;
        in_src_c = c;
        exp_valid = v;
        if (v) exp_result = word_ref(op, a, b, c);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [15:0] rand_half();
        logic [15:0] pool [10] = '{16'h0000, 16'h8000, 16'h7c00, 16'hfc00, 16'h7e00,
                                   16'h7d01, 16'h0001, 16'h83ff, 16'h3c00, 16'h7bff};
        if ($urandom % 6 == 0) return pool[$urandom % 10];
        return 16'($urandom);
    endfunction

    function automatic logic [W-1:0] rand_word();
        return {rand_half(), rand_half()};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b1;
        in_op = 5'd15;
        in_src_a = 32'h3c003c00;
        in_src_b = 32'h3c003c00;
        repeat (3) @(negedge clk);
        compare("R11");
        rst = 1'b0;

        // R1: each operation on ordinary values
        step(1, 5'd14, 32'h40003e00, 32'h42004000, 32'hbc003c00, "R1");
        step(1, 5'd15, 32'h3c004000, 32'h40003c00, 32'h12345678, "R1");
        step(1, 5'd16, 32'h3e00c000, 32'h40004200, 32'h0, "R1");
        step(1, 5'd17, 32'h4000c200, 32'h3c004200, 32'h0, "R1");
        step(1, 5'd18, 32'h4000c200, 32'h3c004200, 32'h0, "R1");

        // R2: lanes with unlike data stay apart
        step(1, 5'd15, 32'h7e003c00, 32'h3c003c00, 32'h0, "R2");
        step(1, 5'd16, 32'h3c007c00, 32'h40000000, 32'h0, "R2");
        step(1, 5'd14, 32'h00014000, 32'h3c004000, 32'h7c00bc00, "R2");

        // R3: single rounding (early rounding of the product would give 0x1c00) and subnormals
        step(1, 5'd14, 32'h3c013c01, 32'h3c033c03, 32'hbc00bc00, "R3");
        step(1, 5'd14, 32'h00010001, 32'h38003a00, 32'h00000000, "R3");
        step(1, 5'd15, 32'h03ff0001, 32'h00010001, 32'h0, "R3");
        step(1, 5'd16, 32'h04000001, 32'h38003800, 32'h0, "R3");
        step(1, 5'd14, 32'h7bff0400, 32'h3c00b800, 32'h3c000001, "R3");

        // R4: source c has no effect on add or multiply
        step(1, 5'd15, 32'h3e004100, 32'hc0003555, 32'h00000000, "R4");
        step(1, 5'd15, 32'h3e004100, 32'hc0003555, 32'hffffffff, "R4");
        step(1, 5'd16, 32'h3e004100, 32'hc0003555, 32'h7e007c00, "R4");
        step(1, 5'd16, 32'h3e004100, 32'hc0003555, 32'h80008000, "R4");

        // R5: overflow to signed infinity
        step(1, 5'd15, 32'h7bfffbff, 32'h7bfffbff, 32'h0, "R5");
        step(1, 5'd16, 32'h7bff7bff, 32'h4000c000, 32'h0, "R5");
        step(1, 5'd15, 32'h7bff7bff, 32'h4fff5000, 32'h0, "R5");

        // R6: invalid operations and NaN operands give 0x7E00
        step(1, 5'd14, 32'h7c000000, 32'h0000fc00, 32'h3c003c00, "R6");
        step(1, 5'd15, 32'h7c00fd01, 32'hfc003c00, 32'h0, "R6");
        step(1, 5'd16, 32'hfe007c00, 32'h3c008000, 32'h0, "R6");
        step(1, 5'd14, 32'h7c003c00, 32'h3c003c00, 32'hfc007d00, "R6");

        // R7: NaN handling in minimum and maximum
        step(1, 5'd17, 32'h7e003c00, 32'h3c00fd00, 32'h0, "R7");
        step(1, 5'd18, 32'h7e003c00, 32'h3c00fd00, 32'h0, "R7");
        step(1, 5'd17, 32'h7e01fc01, 32'hffff7c01, 32'h0, "R7");

        // R8: signed zero ordering
        step(1, 5'd17, 32'h00008000, 32'h80000000, 32'h0, "R8");
        step(1, 5'd18, 32'h00008000, 32'h80000000, 32'h0, "R8");

        // R12: zero signs
        step(1, 5'd15, 32'h3c008000, 32'hbc008000, 32'h0, "R12");
        step(1, 5'd16, 32'h80000000, 32'h3c00bc00, 32'h0, "R12");
        step(1, 5'd14, 32'h00003c00, 32'hbc003c00, 32'h8000bc00, "R12");

        // R9: undefined operation codes
        step(1, 5'd0,  32'h3c003c00, 32'h3c003c00, 32'h3c003c00, "R9");
        step(1, 5'd13, 32'h3c003c00, 32'h3c003c00, 32'h3c003c00, "R9");
        step(1, 5'd19, 32'h3c003c00, 32'h3c003c00, 32'h3c003c00, "R9");
        step(1, 5'd31, 32'h7e007c00, 32'h3c003c00, 32'h3c003c00, "R9");

        // R10: idle cycles hold the last result
        step(1, 5'd15, 32'h40004000, 32'h40004000, 32'h0, "R10");
        step(0, 5'd16, 32'h7bff7bff, 32'h7bff7bff, 32'h0, "R10");
        step(0, 5'd0,  32'h12345678, 32'h9abcdef0, 32'h0, "R10");
        step(1, 5'd17, 32'h3c00bc00, 32'hbc003c00, 32'h0, "R10");

        // random stream
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] op;
            int r = $urandom % 10;
            if (r < 8) op = 5'(14 + $urandom % 5);
            else       op = 5'($urandom);
            step(($urandom % 5) != 0, op, rand_word(), rand_word(), rand_word(), "R1");
        end

        // R11: reset in the middle of a stream
        step(1, 5'd15, 32'h3c003c00, 32'h3c003c00, 32'h0, "R11");
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        exp_valid = 1'b0;
        exp_result = '0;
        compare("R11");
        rst = 1'b0;
        step(1, 5'd18, 32'h3c00c000, 32'h4000c200, 32'h0, "R11");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule